// File: doc/BRIEF.md
# Memory Protection Region Register Bank

This block stores the per-region settings that a memory protection unit needs: one eight-bit control byte and one 32-bit address word for each of a parameterised number of regions (1 to 16). Software reads and writes these registers through a simple register-style port. The port carries an enable, a write flag, a select that picks either the control byte or the address word, a region index and write data. Read data comes back one clock after the request.

A granularity parameter G sets the smallest region the protection unit can describe, which is 2^(G+2) bytes. The block applies G in two ways. When a write asks for the four-byte aligned mode and G is not zero, that write is turned into the disabled mode. When G is two or more, the low G-1 bits of an address word are shaped on readback according to the region's current mode. Any region can be marked at elaboration as fixed. A fixed region returns constant values, takes no writes and is exempt from the granularity rules.

Top module: `pmp_regfile`

## Requirements
- R1: After synchronous reset, every non-fixed region's control byte and address word read as zero, and rd_data is zero.
- R2: A read (acc_en=1, acc_we=0) puts the selected value on rd_data at the next rising edge. rd_data holds its value in every cycle that does not carry a read, writes included.
- R3: The control byte layout is: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 disabled, 1 top-of-range, 2 four-byte aligned, 3 naturally aligned power of two), bit 7 lock. Bits 6:5 always read 0. A control read returns the byte zero-extended in rd_data[7:0].
- R4: With G greater than 0, a control write whose mode field is 2 stores mode 0 and keeps the other bits.
- R5: An address write (acc_sel=1) stores all 32 bits. While the region's mode is top-of-range, every stored bit reads back unchanged.
- R6: With G of at least 2, while the region's mode is disabled, address bits G-2:0 read as 0.
- R7: With G of at least 2, while the region's mode is naturally aligned power of two, address bits G-2:0 read as 1.
- R8: The shaping in R6 and R7 affects readback only. Changing the mode back to top-of-range shows the bits that were written.
- R9: A fixed region returns its elaboration constants for both registers with no granularity shaping, and ignores writes.
- R10: A region index at or above the region count reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = control byte, 1 = address word |
| acc_idx | input | 4 | Region index |
| acc_wdata | input | 32 | Write data (control writes use bits 7:0) |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions take for granted that acc_en, acc_we, acc_sel and acc_idx are steady across each rising edge and known whenever acc_en is high. They also take for granted that software never needs read and write in the same cycle, since a request is either one or the other. The bench drives every request on the falling edge, holds it for exactly one cycle and then returns acc_en to 0, so each access is single and cleanly timed. Out-of-range indices are driven on purpose, because the block has to handle them.

// File: rtl/pmp_rf_pkg.sv
package pmp_rf_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } region_mode_e;

  localparam int CFG_W   = 8;
  localparam int ADDR_W  = 32;
  localparam int MODE_LO = 3;
  localparam int MODE_HI = 4;
  localparam int IDX_W   = 4;
endpackage

// File: rtl/pmp_cfg_legal.sv
module pmp_cfg_legal
  import pmp_rf_pkg::*;
#(
  parameter int GRAIN = 2
) (
  input  logic [CFG_W-1:0] raw_i,
  output logic [CFG_W-1:0] legal_o
);
  logic [1:0] mode_in;
  logic [1:0] mode_out;

  assign mode_in = raw_i[MODE_HI:MODE_LO];

  generate
    if (GRAIN > 0) begin : g_no_na4
      assign mode_out = (mode_in == MODE_NA4) ? MODE_OFF : mode_in;
    end else begin : g_keep
      assign mode_out = mode_in;
    end
  endgenerate

  assign legal_o = {raw_i[7], 2'b00, mode_out, raw_i[2:0]};
endmodule

// File: rtl/pmp_addr_view.sv
module pmp_addr_view
  import pmp_rf_pkg::*;
#(
  parameter int GRAIN = 2
) (
  input  logic [ADDR_W-1:0] stored_i,
  input  logic [1:0]        mode_i,
  output logic [ADDR_W-1:0] view_o
);
  generate
    if (GRAIN >= 2) begin : g_shape
      localparam int LOWN = GRAIN - 1;
      localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << LOWN) - ADDR_W'(1);
      always_comb begin
        view_o = stored_i;
        if (mode_i == MODE_OFF)   view_o = stored_i & ~LOW_MASK;
        if (mode_i == MODE_NAPOT) view_o = stored_i | LOW_MASK;
      end
    end else begin : g_plain
      logic unused_mode;
      assign unused_mode = ^mode_i;
      assign view_o = stored_i;
    end
  endgenerate
endmodule

// File: rtl/pmp_region.sv
module pmp_region
  import pmp_rf_pkg::*;
#(
  parameter int GRAIN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_cfg,
  input  logic              we_addr,
  input  logic [ADDR_W-1:0] wdata,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [ADDR_W-1:0] addr_rd_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic [CFG_W-1:0]  cfg_legal;
  logic [ADDR_W-1:0] addr_q;

  pmp_cfg_legal #(.GRAIN(GRAIN)) u_legal (
    .raw_i  (wdata[CFG_W-1:0]),
    .legal_o(cfg_legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (we_cfg)  cfg_q  <= cfg_legal;
      if (we_addr) addr_q <= wdata;
    end
  end

  pmp_addr_view #(.GRAIN(GRAIN)) u_view (
    .stored_i(addr_q),
    .mode_i  (cfg_q[MODE_HI:MODE_LO]),
    .view_o  (addr_rd_o)
  );

  assign cfg_o = cfg_q;

  // R3
  cfg_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q[6:5] == 2'b00);

  // R4
  no_na4_stored_chk: assert property (@(posedge clk) disable iff (rst)
    (GRAIN > 0) |-> (cfg_q[MODE_HI:MODE_LO] != MODE_NA4));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_addr |=> $stable(addr_q));
endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_rf_pkg::*;
#(
  parameter int                     NREG    = 4,
  parameter int                     GRAIN   = 2,
  parameter logic [NREG-1:0]        HW_MASK = 4'b1000,
  parameter logic [NREG*CFG_W-1:0]  HW_CFG  = {8'h9A, 24'h0},
  parameter logic [NREG*ADDR_W-1:0] HW_ADDR = {32'h0000_1234, 96'h0}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic              acc_sel,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [ADDR_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int NSLOT = 1 << IDX_W;

  logic [CFG_W-1:0]  cfg_arr  [NREG];
  logic [ADDR_W-1:0] addr_arr [NREG];
  logic [ADDR_W-1:0] rd_next;
  logic              rd_req;

  assign rd_req = acc_en && !acc_we;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (HW_MASK[i]) begin : g_fixed
        assign cfg_arr[i]  = HW_CFG[i*CFG_W +: CFG_W];
        assign addr_arr[i] = HW_ADDR[i*ADDR_W +: ADDR_W];
      end else begin : g_soft
        logic hit;
        assign hit = acc_en && acc_we && (acc_idx == IDX_W'(i));
        pmp_region #(.GRAIN(GRAIN)) u_region (
          .clk      (clk),
          .rst      (rst),
          .we_cfg   (hit && !acc_sel),
          .we_addr  (hit && acc_sel),
          .wdata    (acc_wdata),
          .cfg_o    (cfg_arr[i]),
          .addr_rd_o(addr_arr[i])
        );
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NREG; i++) begin
      if (acc_idx == IDX_W'(i))
        rd_next = acc_sel ? addr_arr[i] : {{(ADDR_W-CFG_W){1'b0}}, cfg_arr[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_req) rd_data <= rd_next;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));

  // R10
  out_of_range_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (int'(acc_idx) >= NREG) && (NREG < NSLOT)) |=> (rd_data == '0));
endmodule

// File: tb/pmp_regfile_tb.sv
module pmp_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0;
  logic        acc_we = 1'b0;
  logic        acc_sel = 1'b0;
  logic [3:0]  acc_idx = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmp_regfile u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
    .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_sel = sel; acc_idx = idx; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [3:0] idx, output logic [31:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_sel = sel; acc_idx = idx;
    @(negedge clk);
    acc_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rd_data", rd_data, 32'h0);
    for (int i = 0; i < 3; i++) begin
      rd(1'b0, 4'(i), v); check("R1 cfg", v, 32'h0);
      rd(1'b1, 4'(i), v); check("R1 addr", v, 32'h0);
    end
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(1'b0, 4'd0, 32'hFFFF_FFFF); rd(1'b0, 4'd0, v);
    check("R3 pad bits cleared", v, 32'h0000_009F);
    wr(1'b0, 4'd0, 32'h0000_000F); rd(1'b0, 4'd0, v);
    check("R3 tor rwx", v, 32'h0000_000F);
  endtask

  task automatic t_na4();
    logic [31:0] v;
    wr(1'b0, 4'd2, 32'h0000_0093); rd(1'b0, 4'd2, v);
    check("R4 na4 to off", v, 32'h0000_0083);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(1'b0, 4'd1, 32'h0000_0008);
    wr(1'b1, 4'd1, 32'hABCD_EF03); rd(1'b1, 4'd1, v);
    check("R5 tor full", v, 32'hABCD_EF03);
    wr(1'b0, 4'd1, 32'h0000_0000); rd(1'b1, 4'd1, v);
    check("R6 off low zero", v, 32'hABCD_EF02);
    wr(1'b0, 4'd1, 32'h0000_0018);
    wr(1'b1, 4'd1, 32'h1000_0000); rd(1'b1, 4'd1, v);
    check("R7 napot low one", v, 32'h1000_0001);
    wr(1'b0, 4'd1, 32'h0000_0008); rd(1'b1, 4'd1, v);
    check("R8 stored kept", v, 32'h1000_0000);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    rd(1'b0, 4'd3, v); check("R9 fixed cfg", v, 32'h0000_009A);
    rd(1'b1, 4'd3, v); check("R9 fixed addr unshaped", v, 32'h0000_1234);
    wr(1'b0, 4'd3, 32'h0000_0000); wr(1'b1, 4'd3, 32'hFFFF_FFFF);
    rd(1'b0, 4'd3, v); check("R9 cfg write ignored", v, 32'h0000_009A);
    rd(1'b1, 4'd3, v); check("R9 addr write ignored", v, 32'h0000_1234);
  endtask

  task automatic t_range();
    logic [31:0] v;
    wr(1'b0, 4'd5, 32'h0000_00FF); wr(1'b1, 4'd5, 32'h5555_5555);
    rd(1'b0, 4'd5, v); check("R10 oob cfg", v, 32'h0);
    rd(1'b1, 4'd5, v); check("R10 oob addr", v, 32'h0);
    rd(1'b0, 4'd0, v); check("R10 region0 untouched", v, 32'h0000_000F);
    rd(1'b1, 4'd1, v); check("R10 region1 untouched", v, 32'h1000_0000);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    rd(1'b1, 4'd1, v);
    wr(1'b1, 4'd1, 32'h2222_2222);
    check("R2 hold across write", rd_data, 32'h1000_0000);
    rd(1'b1, 4'd1, v); check("R2 new read", v, 32'h2222_2222);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_na4();
    t_addr();
    t_fixed();
    t_range();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 20000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule